// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and date in packed BCD. A low-frequency reference clock, nominally 32.768 kHz, drives two chained dividers. The first divides by `ASYNC_DIV` (default 128) and gives a fine tick. The second divides that tick by `SYNC_DIV` (default 256) and gives a one-second tick. The count of the second divider is the subsecond value. Each second tick advances a ripple of seconds, minutes, hours, weekday, date, month and two-digit year. The date ripple applies month lengths and the leap-year rule.

Software writes the time fields through a byte-wide register port. It does this while `init_mode` is held high, which stops and clears the dividers. Two alarms compare the running time against programmed seconds, minutes, hour and date values. Any of these fields can be masked out of an alarm. A periodic wakeup down-counter counts either fine ticks or seconds. Alarm and wakeup events set sticky flags, and a combined wakeup request is raised from those flags.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: The seconds field advances exactly once every `ASYNC_DIV*SYNC_DIV` clock cycles. `out_subsec` counts fine ticks from 0 to `SYNC_DIV-1` and returns to 0 on the cycle the seconds field advances.
- R2: Seconds and minutes count in BCD from 00 to 59. A value of 59 wraps to 00 and carries into the next field.
- R3: The 24-hour format is selected when control bit 0 (address 7) is 0. In this format, hours count 00 to 23, and 23 wraps to 00 with a carry into the day fields.
- R4: The 12-hour format is selected when control bit 0 is 1. The hour byte holds the BCD hour in bits 5:0 and the PM indicator in bit 6. The hour sequence is 12, 01 … 11. The step from 11 to 12 inverts bit 6, and the step from 11 PM to 12 AM advances the day.
- R5: The weekday runs 1 to 7 and returns to 1 at each day change.
- R6: The date rolls to 01 after 31 for months 01, 03, 05, 07, 08, 10 and 12, and after 30 for months 04, 06, 09 and 11. For month 02 it rolls after 28, or after 29 in a leap year. A leap year has an even tens digit with a units digit of 0, 4 or 8, or an odd tens digit with a units digit of 2 or 6. Month 12 wraps to 01 and year 99 wraps to 00.
- R7: While `init_mode` is high, the time fields hold their values and the dividers are cleared. Writes to addresses 0 to 6 (second, minute, hour, weekday, date, month, year) are accepted in this state. After release, the first seconds step comes exactly `ASYNC_DIV*SYNC_DIV` cycles later.
- R8: Writes to addresses 0 to 6 while `init_mode` is low have no effect on the time.
- R9: Alarm 0 is configured at addresses 8 to 11 and alarm 1 at addresses 12 to 15. Within each alarm, the four addresses hold second, minute, hour and date. Bit 7 of each configuration byte masks that field, so a masked field always matches. An alarm is enabled by control bit 1 (alarm 0) or control bit 2 (alarm 1). An enabled alarm sets `alarm_flag[i]` on the clock after a seconds step that leaves the time matching it.
- R10: `flag_clr` bits 0, 1 and 2 clear alarm flag 0, alarm flag 1 and `wu_flag`. When a set and a clear of the same flag fall in the same cycle, the set wins.
- R11: The wakeup timer is enabled by control bit 3, and control bit 4 selects its tick: 0 for the fine tick, 1 for the seconds tick. The 16-bit period is written at address 16 (low byte) and address 17 (high byte). While disabled, the counter reloads the period. While enabled, it sets `wu_flag` once every period+1 ticks.
- R12: `wakeup_out` is high whenever any alarm flag or `wu_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode | input | 1 | Stop counting and allow time writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| flag_clr | input | 3 | Flag clear: bit0 alarm 0, bit1 alarm 1, bit2 wakeup |
| out_sec | output | 8 | BCD seconds |
| out_min | output | 8 | BCD minutes |
| out_hour | output | 8 | BCD hour, bit 6 PM |
| out_wday | output | 8 | Weekday 1..7 |
| out_date | output | 8 | BCD day of month |
| out_month | output | 8 | BCD month |
| out_year | output | 8 | BCD year |
| out_subsec | output | $clog2(SYNC_DIV) | Subsecond count |
| alarm_flag | output | 2 | Sticky alarm flags |
| wu_flag | output | 1 | Sticky wakeup timer flag |
| wakeup_out | output | 1 | Combined wakeup request |

## Verification
The range properties on weekday and date assume that software only loads legal BCD values: a weekday from 1 to 7, a date no larger than the length of the loaded month, and an hour that is legal for the selected format. The bench keeps to this by loading only valid calendar points through the init sequence. It also only writes time addresses outside init mode to test that such writes are ignored. The properties also assume that time writes occur only under `init_mode`. For that reason, the hold and step properties treat a write in init mode as the only source of change other than the seconds tick.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  typedef struct packed {
    logic [7:0] ss;
    logic [7:0] mm;
    logic [7:0] hh;
    logic [7:0] wd;
    logic [7:0] dd;
    logic [7:0] mo;
    logic [7:0] yy;
  } rtc_time_t;

  localparam int CTL_H12   = 0;
  localparam int CTL_ALM0  = 1;
  localparam int CTL_WU_EN = 3;
  localparam int CTL_WU_SEL = 4;
  localparam int CTL_W     = 5;

  localparam logic [4:0] ADR_CTRL  = 5'd7;
  localparam logic [4:0] ADR_WU_LO = 5'd16;
  localparam logic [4:0] ADR_WU_HI = 5'd17;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic leap_bcd(input logic [7:0] y);
    logic [3:0] u;
    u = y[3:0];
    if (y[4] == 1'b0) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    else              return (u == 4'd2) || (u == 4'd6);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yy);
    case (mo)
      8'h02:                      return leap_bcd(yy) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int ASYNC_DIV = 128,
  parameter int SYNC_DIV  = 256,
  localparam int AW = $clog2(ASYNC_DIV),
  localparam int SW = $clog2(SYNC_DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic          fine_tick,
  output logic          sec_tick,
  output logic [SW-1:0] subsec
);
  logic [AW-1:0] acnt_q, acnt_d;
  logic [SW-1:0] scnt_q, scnt_d;

  always_comb begin
    fine_tick = !hold && (acnt_q == AW'(ASYNC_DIV - 1));
    sec_tick  = fine_tick && (scnt_q == SW'(SYNC_DIV - 1));
    acnt_d    = (hold || fine_tick) ? '0 : acnt_q + 1'b1;
    scnt_d    = scnt_q;
    if (hold)           scnt_d = '0;
    else if (sec_tick)  scnt_d = '0;
    else if (fine_tick) scnt_d = scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt_q <= '0;
      scnt_q <= '0;
    end else begin
      acnt_q <= acnt_d;
      scnt_q <= scnt_d;
    end
  end

  assign subsec = scnt_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_bcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick,
  input  logic      h12,
  input  logic      wr_time,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output rtc_time_t time_q
);
  rtc_time_t t_d;
  logic      day_c;

  always_comb begin
    t_d   = time_q;
    day_c = 1'b0;
    if (sec_tick) begin
      if (time_q.ss == 8'h59) begin
        t_d.ss = 8'h00;
        if (time_q.mm == 8'h59) begin
          t_d.mm = 8'h00;
          if (h12) begin
            case (time_q.hh[5:0])
              6'h11: begin
                t_d.hh = {1'b0, ~time_q.hh[6], 6'h12};
                day_c  = time_q.hh[6];
              end
              6'h12:   t_d.hh = {1'b0, time_q.hh[6], 6'h01};
              default: t_d.hh = bcd_inc(time_q.hh);
            endcase
          end else if (time_q.hh == 8'h23) begin
            t_d.hh = 8'h00;
            day_c  = 1'b1;
          end else begin
            t_d.hh = bcd_inc(time_q.hh);
          end
        end else begin
          t_d.mm = bcd_inc(time_q.mm);
        end
      end else begin
        t_d.ss = bcd_inc(time_q.ss);
      end
      if (day_c) begin
        t_d.wd = (time_q.wd == 8'd7) ? 8'd1 : time_q.wd + 8'd1;
        if (time_q.dd == month_len(time_q.mo, time_q.yy)) begin
          t_d.dd = 8'h01;
          if (time_q.mo == 8'h12) begin
            t_d.mo = 8'h01;
            t_d.yy = (time_q.yy == 8'h99) ? 8'h00 : bcd_inc(time_q.yy);
          end else begin
            t_d.mo = bcd_inc(time_q.mo);
          end
        end else begin
          t_d.dd = bcd_inc(time_q.dd);
        end
      end
    end
    if (wr_time) begin
      case (wr_addr)
        3'd0:    t_d.ss = wr_data & 8'h7F;
        3'd1:    t_d.mm = wr_data & 8'h7F;
        3'd2:    t_d.hh = wr_data & 8'h7F;
        3'd3:    t_d.wd = wr_data & 8'h07;
        3'd4:    t_d.dd = wr_data & 8'h3F;
        3'd5:    t_d.mo = wr_data & 8'h1F;
        3'd6:    t_d.yy = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '{ss: 8'h00, mm: 8'h00, hh: 8'h00, wd: 8'd1,
                            dd: 8'h01, mo: 8'h01, yy: 8'h00};
    else        time_q <= t_d;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       upd,
  input  rtc_time_t  now,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_data,
  input  logic       clr,
  output logic       flag
);
  logic [3:0][7:0] cfg_q, cfg_d;
  logic            hit, flag_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d[cfg_sel] = cfg_data;
    hit = (cfg_q[0][7] || (cfg_q[0][6:0] == now.ss[6:0])) &&
          (cfg_q[1][7] || (cfg_q[1][6:0] == now.mm[6:0])) &&
          (cfg_q[2][7] || (cfg_q[2][6:0] == now.hh[6:0])) &&
          (cfg_q[3][7] || (cfg_q[3][5:0] == now.dd[5:0]));
    flag_d = flag;
    if (enable && upd && hit) flag_d = 1'b1;
    else if (clr)             flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      flag  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      flag  <= flag_d;
    end
  end
endmodule

// File: rtl/rtc_wakeup.sv
module rtc_wakeup #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         tick,
  input  logic [W-1:0] period,
  input  logic         clr,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         expire, flag_d;

  always_comb begin
    expire = enable && tick && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (!enable || expire) cnt_d = period;
    else if (tick)         cnt_d = cnt_q - 1'b1;
    flag_d = expire ? 1'b1 : (clr ? 1'b0 : flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flag  <= flag_d;
    end
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_bcd_pkg::*;
#(
  parameter int ASYNC_DIV = 128,
  parameter int SYNC_DIV  = 256,
  localparam int SUB_W = $clog2(SYNC_DIV),
  localparam int N_ALM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_mode,
  input  logic             wr_en,
  input  logic [4:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       flag_clr,
  output logic [7:0]       out_sec,
  output logic [7:0]       out_min,
  output logic [7:0]       out_hour,
  output logic [7:0]       out_wday,
  output logic [7:0]       out_date,
  output logic [7:0]       out_month,
  output logic [7:0]       out_year,
  output logic [SUB_W-1:0] out_subsec,
  output logic [N_ALM-1:0] alarm_flag,
  output logic             wu_flag,
  output logic             wakeup_out
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic [15:0]      period_q, period_d;
  logic             upd_q;
  logic             fine_tick, sec_tick, wu_en, wu_tick, wr_time;
  rtc_time_t        now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    ctrl_d   = ctrl_q;
    period_d = period_q;
    if (wr_en && wr_addr == ADR_CTRL)  ctrl_d = wr_data[CTL_W-1:0];
    if (wr_en && wr_addr == ADR_WU_LO) period_d[7:0]  = wr_data;
    if (wr_en && wr_addr == ADR_WU_HI) period_d[15:8] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      upd_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      upd_q    <= sec_tick;
    end
  end

  assign wr_time = init_mode && wr_en && (wr_addr < 5'd7);
  assign wu_en   = ctrl_q[CTL_WU_EN];
  assign wu_tick = ctrl_q[CTL_WU_SEL] ? sec_tick : fine_tick;

  rtc_prescaler #(.ASYNC_DIV(ASYNC_DIV), .SYNC_DIV(SYNC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_sync_n), .hold(init_mode),
    .fine_tick(fine_tick), .sec_tick(sec_tick), .subsec(out_subsec)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_sync_n), .sec_tick(sec_tick), .h12(ctrl_q[CTL_H12]),
    .wr_time(wr_time), .wr_addr(wr_addr[2:0]), .wr_data(wr_data), .time_q(now)
  );

  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    rtc_alarm u_alm (
      .clk(clk), .rst_n(rst_sync_n), .enable(ctrl_q[CTL_ALM0 + i]), .upd(upd_q),
      .now(now), .cfg_wr(wr_en && (wr_addr[4:2] == 3'(2 + i))),
      .cfg_sel(wr_addr[1:0]), .cfg_data(wr_data), .clr(flag_clr[i]),
      .flag(alarm_flag[i])
    );
  end

  rtc_wakeup #(.W(16)) u_wu (
    .clk(clk), .rst_n(rst_sync_n), .enable(wu_en), .tick(wu_tick),
    .period(period_q), .clr(flag_clr[2]), .flag(wu_flag)
  );

  assign out_sec    = now.ss;
  assign out_min    = now.mm;
  assign out_hour   = now.hh;
  assign out_wday   = now.wd;
  assign out_date   = now.dd;
  assign out_month  = now.mo;
  assign out_year   = now.yy;
  assign wakeup_out = (|alarm_flag) || wu_flag;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_mode,
  input logic       wr_en,
  input logic       sec_tick,
  input logic       wu_en,
  input logic [7:0] out_sec,
  input logic [7:0] out_min,
  input logic [7:0] out_wday,
  input logic [7:0] out_date,
  input logic       wu_flag
);
  // R1: seconds move only on a seconds tick or an init-mode write
  p_sec_only_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !(init_mode && wr_en)) |=> $stable(out_sec));

  // R2: 59 seconds wrap to 00 on the next tick
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && out_sec == 8'h59) |=> (out_sec == 8'h00));

  // R5: weekday stays within 1..7
  p_wday_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wday >= 8'd1) && (out_wday <= 8'd7));

  // R6: date never zero nor beyond 31
  p_date_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_date != 8'h00) && (out_date <= 8'h31));

  // R7: without writes the time holds in init mode
  p_hold_in_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_mode && !wr_en) |=> ($stable(out_sec) && $stable(out_min) && $stable(out_date)));

  // R11: the wakeup flag only rises while the timer is enabled
  p_wu_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wu_flag) |-> $past(wu_en));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .init_mode(init_mode), .wr_en(wr_en),
  .sec_tick(sec_tick), .wu_en(wu_en), .out_sec(out_sec), .out_min(out_min),
  .out_wday(out_wday), .out_date(out_date), .wu_flag(wu_flag)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  localparam int ADIV = 2;
  localparam int SDIV = 4;
  localparam int SPS  = ADIV * SDIV;

  logic       clk, rst_n, init_mode, wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] flag_clr;
  logic [7:0] out_sec, out_min, out_hour, out_wday, out_date, out_month, out_year;
  logic [1:0] out_subsec;
  logic [1:0] alarm_flag;
  logic       wu_flag, wakeup_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ctrl_sh = 8'h00;

  rtc_bcd_calendar #(.ASYNC_DIV(ADIV), .SYNC_DIV(SDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr),
    .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour), .out_wday(out_wday),
    .out_date(out_date), .out_month(out_month), .out_year(out_year),
    .out_subsec(out_subsec), .alarm_flag(alarm_flag), .wu_flag(wu_flag),
    .wakeup_out(wakeup_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_init();
    @(negedge clk);
    init_mode = 1'b1;
  endtask

  task automatic leave_init();
    @(negedge clk);
    init_mode = 1'b0;
  endtask

  task automatic load_time(input logic [7:0] yy, mo, dd, wd, hh, mm, ss);
    enter_init();
    wr(5'd7, ctrl_sh);
    wr(5'd0, ss); wr(5'd1, mm); wr(5'd2, hh); wr(5'd3, wd);
    wr(5'd4, dd); wr(5'd5, mo); wr(5'd6, yy);
    leave_init();
  endtask

  task automatic t_reset();
    chk("R7", "reset sec", out_sec, 8'h00);
    chk("R5", "reset wday", out_wday, 8'd1);
    chk("R6", "reset date", out_date, 8'h01);
    chk("R6", "reset month", out_month, 8'h01);
    chk("R12", "reset wakeup", {alarm_flag, wu_flag, wakeup_out}, 4'h0);
  endtask

  task automatic t_seconds();
    load_time(8'h21, 8'h03, 8'h15, 8'd2, 8'h10, 8'h00, 8'h58);
    wait_edges(SPS - 1);
    chk("R1", "sec before step", out_sec, 8'h58);
    chk("R1", "subsec before step", out_subsec, 2'd3);
    wait_edges(1);
    chk("R1", "sec after step", out_sec, 8'h59);
    chk("R1", "subsec after step", out_subsec, 2'd0);
    wait_edges(SPS);
    chk("R2", "sec wrap", out_sec, 8'h00);
    chk("R2", "min carry", out_min, 8'h01);
  endtask

  task automatic t_day24();
    load_time(8'h21, 8'h03, 8'h15, 8'd7, 8'h23, 8'h59, 8'h59);
    wait_edges(SPS);
    chk("R3", "hour wrap", out_hour, 8'h00);
    chk("R5", "wday wrap", out_wday, 8'd1);
    chk("R3", "date advance", out_date, 8'h16);
    chk("R3", "month kept", out_month, 8'h03);
  endtask

  task automatic t_h12();
    ctrl_sh[0] = 1'b1;
    load_time(8'h21, 8'h01, 8'h10, 8'd3, 8'h11, 8'h59, 8'h59);
    wait_edges(SPS);
    chk("R4", "11AM to 12PM", out_hour, 8'h52);
    chk("R4", "no day at noon", out_date, 8'h10);
    load_time(8'h21, 8'h01, 8'h10, 8'd3, 8'h52, 8'h59, 8'h59);
    wait_edges(SPS);
    chk("R4", "12PM to 1PM", out_hour, 8'h41);
    load_time(8'h21, 8'h01, 8'h10, 8'd3, 8'h51, 8'h59, 8'h59);
    wait_edges(SPS);
    chk("R4", "11PM to 12AM", out_hour, 8'h12);
    chk("R4", "midnight date", out_date, 8'h11);
    chk("R5", "midnight wday", out_wday, 8'd4);
    ctrl_sh[0] = 1'b0;
  endtask

  task automatic day_roll(input logic [7:0] yy, mo, dd, eyy, emo, edd);
    load_time(yy, mo, dd, 8'd1, 8'h23, 8'h59, 8'h59);
    wait_edges(SPS);
    chk("R6", $sformatf("roll %h/%h/%h", yy, mo, dd), {out_year, out_month, out_date}, {8'h00, eyy, emo, edd});
  endtask

  task automatic t_months();
    day_roll(8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    day_roll(8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    day_roll(8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    day_roll(8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29);
    day_roll(8'h12, 8'h02, 8'h28, 8'h12, 8'h02, 8'h29);
    day_roll(8'h10, 8'h02, 8'h28, 8'h10, 8'h03, 8'h01);
    day_roll(8'h21, 8'h04, 8'h30, 8'h21, 8'h05, 8'h01);
    day_roll(8'h21, 8'h01, 8'h30, 8'h21, 8'h01, 8'h31);
    day_roll(8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
  endtask

  task automatic t_init_hold();
    load_time(8'h21, 8'h06, 8'h01, 8'd1, 8'h08, 8'h30, 8'h20);
    wait_edges(3);
    enter_init();
    wait_edges(4 * SPS);
    chk("R7", "sec held in init", out_sec, 8'h20);
    chk("R7", "subsec cleared in init", out_subsec, 2'd0);
    leave_init();
    wait_edges(SPS - 1);
    chk("R7", "no step before period", out_sec, 8'h20);
    wait_edges(1);
    chk("R7", "step after release", out_sec, 8'h21);
  endtask

  task automatic t_ignore();
    load_time(8'h21, 8'h06, 8'h01, 8'd1, 8'h08, 8'h30, 8'h10);
    wr(5'd0, 8'h33);
    wait_edges(SPS - 2);
    chk("R8", "run-time write ignored", out_sec, 8'h11);
    chk("R8", "minute untouched", out_min, 8'h30);
  endtask

  task automatic t_alarm();
    wr(5'd8, 8'h05); wr(5'd9, 8'h80); wr(5'd10, 8'h80); wr(5'd11, 8'h80);
    wr(5'd12, 8'h05); wr(5'd13, 8'h07); wr(5'd14, 8'h80); wr(5'd15, 8'h80);
    ctrl_sh[2:1] = 2'b11;
    load_time(8'h21, 8'h06, 8'h01, 8'd1, 8'h00, 8'h00, 8'h03);
    wait_edges(2 * SPS);
    chk("R9", "time at alarm", out_sec, 8'h05);
    chk("R9", "flag one cycle later", alarm_flag[0], 1'b0);
    wait_edges(1);
    chk("R9", "masked alarm fires", alarm_flag[0], 1'b1);
    chk("R9", "unmasked minute blocks", alarm_flag[1], 1'b0);
    chk("R12", "wakeup from alarm", wakeup_out, 1'b1);
  endtask

  task automatic t_clear();
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R10", "alarm flag cleared", alarm_flag[0], 1'b0);
    wr(5'd8, 8'h80);
    enter_init();
    flag_clr = 3'b001;
    leave_init();
    wait_edges(SPS + 1);
    chk("R10", "set wins over clear", alarm_flag[0], 1'b1);
    wait_edges(1);
    chk("R10", "clear after set", alarm_flag[0], 1'b0);
    ctrl_sh[2:1] = 2'b00;
    wr(5'd7, ctrl_sh);
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R10", "all flags clear", {alarm_flag, wu_flag}, 3'b000);
  endtask

  task automatic t_wakeup();
    enter_init();
    wr(5'd16, 8'h02); wr(5'd17, 8'h00);
    ctrl_sh[4:3] = 2'b01;
    wr(5'd7, ctrl_sh);
    leave_init();
    wait_edges(5);
    chk("R11", "no wakeup early", wu_flag, 1'b0);
    chk("R12", "no request early", wakeup_out, 1'b0);
    wait_edges(1);
    chk("R11", "wakeup after 3 fine ticks", wu_flag, 1'b1);
    chk("R12", "request from timer", wakeup_out, 1'b1);
    flag_clr = 3'b100;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R10", "wakeup flag cleared", wu_flag, 1'b0);
    wait_edges(4);
    chk("R11", "no wakeup mid period", wu_flag, 1'b0);
    wait_edges(1);
    chk("R11", "second wakeup", wu_flag, 1'b1);
    enter_init();
    flag_clr = 3'b100;
    wr(5'd16, 8'h01);
    flag_clr = 3'b000;
    ctrl_sh[4:3] = 2'b00;
    wr(5'd7, ctrl_sh);
    ctrl_sh[4:3] = 2'b11;
    wr(5'd7, ctrl_sh);
    leave_init();
    wait_edges(2 * SPS - 1);
    chk("R11", "seconds base not yet", wu_flag, 1'b0);
    wait_edges(1);
    chk("R11", "seconds base wakeup", wu_flag, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; init_mode = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; flag_clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_seconds();
    t_day24();
    t_h12();
    t_months();
    t_init_hold();
    t_ignore();
    t_alarm();
    t_clear();
    t_wakeup();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule